// File: doc/BRIEF.md
# Dual-law serial clock divider

This block derives the serial clock of a synchronous serial port from the faster module clock. One control word sets the rate. It holds two divisor fields and a law-select bit. With the select bit set, the block divides linearly: the serial clock period is 2*(N+1) module clocks, and N=0 gives half the module clock. With the select bit clear, it divides by a power of two: the period is 2^M module clocks. M=0 is treated as a divide-by-2 request, because a half period cannot be shorter than one module clock. Software chooses the law and computes the fields.

A transfer engine raises `xfer_active_i` for the whole of a transfer. On the first cycle that input is seen high, the block captures the control word and clears its half-period counter. The first serial clock edge therefore comes exactly one half period later. Every toggle produces a one-cycle strobe and a rise or fall pulse that match the new clock level. While no transfer runs, the strobe stays low and the clock rests at the polarity level `cpol_i`.

Top module: `spi_clkdiv`

## Requirements
- R1: With bit 12 set, the half period is N+1 module clocks, where N = control bits [7:0]. Each strobe follows the previous one after exactly that many cycles.
- R2: With bit 12 clear and M = control bits [11:8] at least 1, the half period is 2^(M-1) module clocks.
- R3: With bit 12 clear and M = 0, the half period is 1 module clock. This is the same rate as linear N = 0.
- R4: The law-select bit decides which field counts. In linear mode bits [11:8] have no effect on the rate, and in power-of-two mode bits [7:0] have no effect.
- R5: The control word is captured only on the first active cycle of a transfer. A change while the transfer runs does not alter the current rate. The next transfer uses the new word.
- R6: The first toggle strobe is high in the cycle that follows the H-th rising module clock edge after the capture edge, where H is the half period.
- R7: While `xfer_active_i` is low, the outputs settle one cycle later to this state: `sclk_tgl_o`, `sclk_rise_o` and `sclk_fall_o` low, and `sclk_o` equal to `cpol_i`.
- R8: In the cycle of each toggle strobe, `sclk_o` has just inverted. Exactly one of `sclk_rise_o` (new level 1) or `sclk_fall_o` (new level 0) is high, and the two alternate.
- R9: If `xfer_active_i` drops in the middle of a transfer, the block is idle (R7) one cycle later. A fresh transfer then restarts timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_active_i | input | 1 | High for the duration of a transfer |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_ctrl_i | input | 13 | Bits [7:0] linear field, [11:8] exponent field, [12] law select (1 = linear) |
| sclk_o | output | 1 | Serial clock level |
| sclk_tgl_o | output | 1 | One-cycle strobe on every serial clock toggle |
| sclk_rise_o | output | 1 | Strobe on a toggle to level 1 |
| sclk_fall_o | output | 1 | Strobe on a toggle to level 0 |

## Verification
The linear field is swept over all 256 values, and the exponent field over 0 to 12 plus 15. In each case the bench measures the cycles to the first strobe and between strobes, and compares them with arithmetic values. This separates the off-by-one forms of each law, and it shows whether M=0 is clamped. The unused field carries junk values, which shows that the law-select bit isolates the fields. The polarity alternates between cases, which tells rise from fall. A further run changes the word in mid-transfer and then aborts and restarts. This separates capture at the start of a transfer from continuous sampling.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spi_clkdiv_ratio.sv
module spi_clkdiv_ratio
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned LIN_W  = 8,
   parameter int unsigned EXP_W  = 4,
   parameter int unsigned HALF_W = 15,
   localparam int unsigned CTRL_W = LIN_W + EXP_W + 1
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [HALF_W-1:0] half_len_o
);
   logic [LIN_W-1:0]  lin_field;
   logic [EXP_W-1:0]  exp_field;
   div_law_e          law;
   logic [HALF_W-1:0] lin_half;
   logic [HALF_W-1:0] pow_half;

   assign lin_field = ctrl_i[LIN_W-1:0];
   assign exp_field = ctrl_i[LIN_W+EXP_W-1:LIN_W];
   assign law       = div_law_e'(ctrl_i[CTRL_W-1]);

   assign lin_half = HALF_W'(lin_field) + HALF_W'(1);

   always_comb begin
      if (exp_field == '0) pow_half = HALF_W'(1);
      else                 pow_half = HALF_W'(1) << (exp_field - EXP_W'(1));
   end

   assign half_len_o = (law == LAW_LINEAR) ? lin_half : pow_half;
endmodule

// File: rtl/spi_clkdiv_counter.sv
module spi_clkdiv_counter #(
   parameter int unsigned HALF_W = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              run_i,
   input  logic [HALF_W-1:0] half_len_i,
   output logic              hit_o,
   output logic              tgl_o
);
   logic [HALF_W-1:0] half_q;
   logic [HALF_W-1:0] cnt_q;

   assign hit_o = run_i && (cnt_q == half_q - HALF_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_q <= HALF_W'(1);
         cnt_q  <= '0;
         tgl_o  <= 1'b0;
      end else if (start_i) begin
         half_q <= half_len_i;
         cnt_q  <= '0;
         tgl_o  <= 1'b0;
      end else if (run_i) begin
         cnt_q  <= hit_o ? '0 : cnt_q + HALF_W'(1);
         tgl_o  <= hit_o;
      end else begin
         cnt_q  <= '0;
         tgl_o  <= 1'b0;
      end
   end

   assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < half_q);
   assert_ratio_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |=> $stable(half_q));
   assert_start_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (cnt_q == '0) && !tgl_o);
endmodule

// File: rtl/spi_clkdiv_phase.sv
module spi_clkdiv_phase (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic idle_i,
   input  logic cpol_i,
   input  logic hit_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_o <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else if (idle_i) begin
         sclk_o <= cpol_i;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else if (hit_i) begin
         sclk_o <= ~sclk_o;
         rise_o <= ~sclk_o;
         fall_o <= sclk_o;
      end else begin
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end
   end

   assert_edge_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o && fall_o));
   assert_rise_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> sclk_o);
   assert_fall_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> !sclk_o);
   assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_i |=> (sclk_o == $past(cpol_i)));
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned LIN_W = 8,
   parameter int unsigned EXP_W = 4,
   localparam int unsigned CTRL_W = LIN_W + EXP_W + 1,
   localparam int unsigned HALF_W = max2(LIN_W + 1, (1 << EXP_W) - 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              xfer_active_i,
   input  logic              cpol_i,
   input  logic [CTRL_W-1:0] div_ctrl_i,
   output logic              sclk_o,
   output logic              sclk_tgl_o,
   output logic              sclk_rise_o,
   output logic              sclk_fall_o
);
   generate
      if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
         $error("spi_clkdiv: LIN_W out of range");
      end
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("spi_clkdiv: EXP_W out of range");
      end
   endgenerate

   logic              active_q;
   logic              start;
   logic              run;
   logic              hit;
   logic [HALF_W-1:0] half_len;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) active_q <= 1'b0;
      else         active_q <= xfer_active_i;
   end

   assign start = xfer_active_i && !active_q;
   assign run   = xfer_active_i && active_q;

   spi_clkdiv_ratio #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W),
      .HALF_W(HALF_W)
   ) u_ratio (
      .ctrl_i    (div_ctrl_i),
      .half_len_o(half_len)
   );

   spi_clkdiv_counter #(
      .HALF_W(HALF_W)
   ) u_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .run_i     (run),
      .half_len_i(half_len),
      .hit_o     (hit),
      .tgl_o     (sclk_tgl_o)
   );

   spi_clkdiv_phase u_phase (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .idle_i(!xfer_active_i),
      .cpol_i(cpol_i),
      .hit_i (hit),
      .sclk_o(sclk_o),
      .rise_o(sclk_rise_o),
      .fall_o(sclk_fall_o)
   );

   assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !xfer_active_i |=> !sclk_tgl_o && !sclk_rise_o && !sclk_fall_o);
   assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(xfer_active_i) |=> !sclk_tgl_o);
   assert_strobe_pairs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_tgl_o |-> (sclk_rise_o || sclk_fall_o));
endmodule

// File: tb/spi_clkdiv_tb.sv
module spi_clkdiv_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        act = 1'b0;
   logic        cpol = 1'b0;
   logic [12:0] ctrl = '0;
   logic        sclk, tgl, rise, fall;
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;

   always #2.5 clk = ~clk;

   spi_clkdiv u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .xfer_active_i(act),
      .cpol_i       (cpol),
      .div_ctrl_i   (ctrl),
      .sclk_o       (sclk),
      .sclk_tgl_o   (tgl),
      .sclk_rise_o  (rise),
      .sclk_fall_o  (fall)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   task automatic wait_tgl(output int n);
      n = 0;
      do begin
         @(posedge clk); n++; @(negedge clk);
      end while (!tgl && n < 40000);
   endtask

   task automatic idle_check(input string req);
      check({req, " strobe"}, int'(tgl), 0);
      check({req, " edges"}, int'(rise | fall), 0);
      check({req, " level"}, int'(sclk), int'(cpol));
   endtask

   // start a transfer and verify first strobe delay and the next interval
   task automatic run_case(input string req, input logic [12:0] word, input logic pol,
                           input int half);
      int n;
      @(negedge clk);
      act = 1'b0; cpol = pol; ctrl = word;
      @(negedge clk); @(negedge clk);
      idle_check("R7");
      act = 1'b1;
      @(posedge clk);
      wait_tgl(n);
      check({req, " R6 first delay"}, n, half);
      check({req, " R8 level"}, int'(sclk), int'(!pol));
      check({req, " R8 edge"}, int'(pol ? fall : rise), 1);
      wait_tgl(n);
      check({req, " interval"}, n, half);
      check({req, " R8 back edge"}, int'(pol ? rise : fall), 1);
      @(negedge clk);
      act = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check("R7 reset strobe", int'(tgl), 0);
      check("R7 reset level", int'(sclk), 0);
      rst_n = 1'b1;

      // R1 and R4: linear sweep, exponent field carries junk
      for (int k = 0; k < 256; k++)
         run_case("R1 R4 linear", {1'b1, 4'(k), 8'(k)}, 1'(k), k + 1);

      // R2, R3 and R4: power-of-two sweep, linear field carries junk
      for (int m = 0; m <= 15; m++) begin
         if (m <= 12 || m == 15)
            run_case(m == 0 ? "R3 pow2 zero" : "R2 R4 pow2", {1'b0, 4'(m), 8'hA5},
                     1'(m), (m == 0) ? 1 : (1 << (m - 1)));
      end

      // R5: change the word in mid-transfer
      @(negedge clk);
      cpol = 1'b0; ctrl = {1'b1, 4'h0, 8'd3};
      @(negedge clk);
      act = 1'b1;
      @(posedge clk);
      wait_tgl(n);
      check("R5 first before change", n, 4);
      ctrl = {1'b1, 4'h0, 8'd9};
      wait_tgl(n);
      check("R5 rate held after change", n, 4);
      wait_tgl(n);
      check("R5 rate held again", n, 4);

      // R9: abort mid half-period, then restart with the new word
      @(posedge clk); @(negedge clk);
      act = 1'b0;
      @(posedge clk); @(negedge clk);
      idle_check("R9 abort");
      act = 1'b1;
      @(posedge clk);
      wait_tgl(n);
      check("R9 R5 restart uses new word", n, 10);
      @(negedge clk);
      act = 1'b0;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule